// File: doc/BRIEF.md
# Command-Decoding Serial Slave Port

This block is the slave end of a four-wire synchronous serial link: a select line, a serial clock, a data input and a data output. Three static strap inputs fix the select's active level, the clock's idle level and the clock edge used for sampling, so any of the four common clock modes can be served. All serial inputs are oversampled in the system clock domain through two-flop synchronizers, and every bit decision is made there. The system clock must run at least four times faster than the serial clock.

Each select frame starts with a command byte, received most significant bit first. Its top three bits are an opcode. Its low five bits are a byte count for buffer transfers, or a start address for register transfers. The block then moves data bytes between the serial link and two parallel ports, one for a data buffer and one for a control/status register file. It signals each access with a one-cycle strobe. Two opcodes carry no data and produce only a one-cycle system strobe, one for power-off and one for interrupt clearing. The data output has an enable pin for a tri-state pad. An external transparent-receive input can force that enable on.

Top module: `serial_cmd_slave`

## Requirements
- R1: The select is active when `cs_in` equals `cfg_cs_pol` (1 = active high, 0 = active low). While it is inactive, no strobe is produced, and releasing it ends the frame.
- R2: `sdo_oe` is high while the select is active or while `rx_transparent` is high, and low otherwise.
- R3: All four settings of `cfg_sck_pol`/`cfg_sck_pha` work. With pha=0, input is sampled on the first clock edge after idle and output changes on the other edge. With pha=1, the roles of the two edges swap. Command and data bytes travel MSB first.
- R4: Command bit 7:5 selects the action: 000 buffer read, 001 buffer write, 010 register read, 011 register write, 100 off, 101 interrupt clear, 110/111 unused. Bits 4:0 hold the count or the address.
- R5: A buffer read with count N>0 issues N `buf_rd_stb` pulses, one at the end of the command byte and one at the end of each of the following data bytes until N are issued. `buf_rdata` is taken in the strobe cycle and sent as the next data byte. Bytes after the N-th read out as zero. N=0 produces no strobe.
- R6: A buffer write with count N issues one `buf_wr_stb` with `wr_data` equal to the received byte for each of the first N data bytes. Later bytes are ignored.
- R7: A register read pulses `reg_rd_stb` at the end of the command byte with `reg_addr` equal to bits 4:0. It pulses again after each data byte with the address one higher, wrapping from 31 to 0. `reg_rdata` from each strobe cycle is sent as the next byte.
- R8: A register write pulses `reg_wr_stb` after each data byte with `wr_data` equal to that byte. The first write uses address bits 4:0, and each later write uses the next address.
- R9: The off and interrupt-clear opcodes each give exactly one one-cycle pulse on `off_stb` or `irq_clr_stb` after the command byte. Nothing else happens in that frame.
- R10: Unused opcodes produce no strobe, and `sdo` stays 0 for the rest of the frame.
- R11: Releasing the select mid-byte drops the partial byte with no write strobe. The next frame starts again with a command byte.
- R12: At most one strobe output is high in any cycle, and each strobe lasts one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cs_pol | input | 1 | Select active level strap |
| cfg_sck_pol | input | 1 | Serial clock idle level strap |
| cfg_sck_pha | input | 1 | Serial clock sampling phase strap |
| rx_transparent | input | 1 | Forces the output enable on |
| cs_in | input | 1 | Serial select pin |
| sck_in | input | 1 | Serial clock pin |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the data-out pad |
| buf_rd_stb | output | 1 | Buffer read strobe |
| buf_wr_stb | output | 1 | Buffer write strobe |
| buf_rdata | input | 8 | Buffer read data, valid in the strobe cycle |
| reg_rd_stb | output | 1 | Register read strobe |
| reg_wr_stb | output | 1 | Register write strobe |
| reg_addr | output | 5 | Register address |
| reg_rdata | input | 8 | Register read data, valid in the strobe cycle |
| wr_data | output | 8 | Write data for buffer and register writes |
| off_stb | output | 1 | Off command strobe |
| irq_clr_stb | output | 1 | Interrupt-clear strobe |

## Verification
The properties assume three things about the inputs. The serial clock is slow enough that two detected edges of one byte are always several system cycles apart. The strap inputs change only while the select is released. A deselected link stays quiet for a few cycles before a new frame begins. The stimulus runs the serial clock at one sixteenth of the system clock and changes straps only between frames. It moves every pin one nanosecond after a system edge, so the synchronizers never see a change at the sampling instant.

// File: rtl/ssl_pkg.sv
package ssl_pkg;

   typedef enum logic [2:0] {
      OP_BUF_RD  = 3'b000,
      OP_BUF_WR  = 3'b001,
      OP_REG_RD  = 3'b010,
      OP_REG_WR  = 3'b011,
      OP_OFF     = 3'b100,
      OP_IRQ_CLR = 3'b101,
      OP_SPARE_A = 3'b110,
      OP_SPARE_B = 3'b111
   } ssl_op_e;

   typedef enum logic [1:0] {
      PH_CMD  = 2'd0,
      PH_DATA = 2'd1,
      PH_DONE = 2'd2
   } ssl_phase_e;

   typedef struct packed {
      logic buf_rd;
      logic buf_wr;
      logic reg_rd;
      logic reg_wr;
      logic off;
      logic irq_clr;
   } ssl_strobe_t;

endpackage

// File: rtl/ssl_sync.sv
module ssl_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ssl_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("ssl_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg <= {stg[STAGES-2:0], d};
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/ssl_edge.sv
module ssl_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic ck_s,
   input  logic sel_s,
   input  logic pha,
   output logic sample_ev,
   output logic drive_ev
);

   logic ck_d;
   logic lead;
   logic trail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_d <= 1'b0;
      end else begin
         ck_d <= ck_s;
      end
   end

   assign lead      = ck_s & ~ck_d;
   assign trail     = ~ck_s & ck_d;
   assign sample_ev = sel_s & (pha ? trail : lead);
   assign drive_ev  = sel_s & (pha ? lead : trail);

endmodule

// File: rtl/ssl_rx.sv
module ssl_rx #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_s,
   input  logic              sample_ev,
   input  logic              sdi_s,
   output logic              byte_done,
   output logic [DATA_W-1:0] byte_val
);

   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-2:0] sh;

   assign byte_val  = {sh, sdi_s};
   assign byte_done = sample_ev && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sh  <= '0;
      end else if (!sel_s) begin
         cnt <= '0;
         sh  <= '0;
      end else if (sample_ev) begin
         sh  <= byte_val[DATA_W-2:0];
         cnt <= byte_done ? '0 : cnt + 1'b1;
      end
   end

endmodule

// File: rtl/ssl_tx.sv
module ssl_tx #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_s,
   input  logic              drive_ev,
   input  logic              cap_en,
   input  logic [DATA_W-1:0] cap_data,
   output logic              sdo
);

   logic              pend;
   logic [DATA_W-1:0] hold;
   logic [DATA_W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         hold <= '0;
         sh   <= '0;
         sdo  <= 1'b0;
      end else if (!sel_s) begin
         pend <= 1'b0;
         sh   <= '0;
         sdo  <= 1'b0;
      end else begin
         if (cap_en) begin
            pend <= 1'b1;
            hold <= cap_data;
         end
         if (drive_ev) begin
            if (pend) begin
               sdo  <= hold[DATA_W-1];
               sh   <= {hold[DATA_W-2:0], 1'b0};
               pend <= 1'b0;
            end else begin
               sdo <= sh[DATA_W-1];
               sh  <= {sh[DATA_W-2:0], 1'b0};
            end
         end
      end
   end

endmodule

// File: rtl/ssl_ctrl.sv
module ssl_ctrl
   import ssl_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OP_W   = 3,
   localparam int FIELD_W = DATA_W - OP_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel_s,
   input  logic               byte_done,
   input  logic [DATA_W-1:0]  byte_val,
   output ssl_strobe_t        stb,
   output logic [FIELD_W-1:0] addr,
   output logic [DATA_W-1:0]  wr_data
);

   if (OP_W != 3) begin : g_bad_op
      $error("ssl_ctrl: the opcode field must be 3 bits");
   end

   ssl_op_e            op_in;
   logic [FIELD_W-1:0] field;
   ssl_op_e            op;
   ssl_phase_e         phase;
   logic [FIELD_W-1:0] rem;
   logic               adv;

   assign op_in = ssl_op_e'(byte_val[DATA_W-1 -: OP_W]);
   assign field = byte_val[FIELD_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb     <= '0;
         op      <= OP_SPARE_A;
         phase   <= PH_CMD;
         rem     <= '0;
         addr    <= '0;
         adv     <= 1'b0;
         wr_data <= '0;
      end else begin
         stb <= '0;
         if (!sel_s) begin
            phase <= PH_CMD;
            rem   <= '0;
            adv   <= 1'b0;
         end else if (byte_done) begin
            case (phase)
               PH_CMD: begin
                  op    <= op_in;
                  rem   <= field;
                  addr  <= field;
                  adv   <= 1'b0;
                  phase <= PH_DONE;
                  case (op_in)
                     OP_BUF_RD: begin
                        if (field != '0) begin
                           stb.buf_rd <= 1'b1;
                           rem        <= field - 1'b1;
                           phase      <= PH_DATA;
                        end
                     end
                     OP_BUF_WR: begin
                        if (field != '0) phase <= PH_DATA;
                     end
                     OP_REG_RD: begin
                        stb.reg_rd <= 1'b1;
                        phase      <= PH_DATA;
                     end
                     OP_REG_WR:  phase <= PH_DATA;
                     OP_OFF:     stb.off <= 1'b1;
                     OP_IRQ_CLR: stb.irq_clr <= 1'b1;
                     default: ;
                  endcase
               end
               PH_DATA: begin
                  case (op)
                     OP_BUF_RD: begin
                        if (rem != '0) begin
                           stb.buf_rd <= 1'b1;
                           rem        <= rem - 1'b1;
                        end else begin
                           phase <= PH_DONE;
                        end
                     end
                     OP_BUF_WR: begin
                        stb.buf_wr <= 1'b1;
                        wr_data    <= byte_val;
                        rem        <= rem - 1'b1;
                        if (rem == FIELD_W'(1)) phase <= PH_DONE;
                     end
                     OP_REG_RD: begin
                        stb.reg_rd <= 1'b1;
                        addr       <= addr + 1'b1;
                     end
                     OP_REG_WR: begin
                        stb.reg_wr <= 1'b1;
                        wr_data    <= byte_val;
                        if (adv) addr <= addr + 1'b1;
                        adv <= 1'b1;
                     end
                     default: phase <= PH_DONE;
                  endcase
               end
               PH_DONE: ;
               default: phase <= PH_CMD;
            endcase
         end
      end
   end

endmodule

// File: rtl/serial_cmd_slave.sv
module serial_cmd_slave
   import ssl_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OP_W        = 3,
   parameter int SYNC_STAGES = 2,
   localparam int FIELD_W    = DATA_W - OP_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_cs_pol,
   input  logic               cfg_sck_pol,
   input  logic               cfg_sck_pha,
   input  logic               rx_transparent,
   input  logic               cs_in,
   input  logic               sck_in,
   input  logic               sdi,
   output logic               sdo,
   output logic               sdo_oe,
   output logic               buf_rd_stb,
   output logic               buf_wr_stb,
   input  logic [DATA_W-1:0]  buf_rdata,
   output logic               reg_rd_stb,
   output logic               reg_wr_stb,
   output logic [FIELD_W-1:0] reg_addr,
   input  logic [DATA_W-1:0]  reg_rdata,
   output logic [DATA_W-1:0]  wr_data,
   output logic               off_stb,
   output logic               irq_clr_stb
);

   if (DATA_W < 4) begin : g_bad_data
      $error("serial_cmd_slave: DATA_W too small");
   end
   if (FIELD_W < 1) begin : g_bad_field
      $error("serial_cmd_slave: no room for the count field");
   end

   logic              sel_raw;
   logic [2:0]        pins_raw;
   logic [2:0]        pins_s;
   logic              sel_s;
   logic              ck_s;
   logic              sdi_s;
   logic              sample_ev;
   logic              drive_ev;
   logic              byte_done;
   logic [DATA_W-1:0] byte_val;
   ssl_strobe_t       stb;
   logic              cap_en;
   logic [DATA_W-1:0] cap_data;

   assign sel_raw  = ~(cs_in ^ cfg_cs_pol);
   assign pins_raw = {sel_raw, sck_in ^ cfg_sck_pol, sdi};
   assign sdo_oe   = sel_raw | rx_transparent;

   ssl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   assign sel_s = pins_s[2];
   assign ck_s  = pins_s[1];
   assign sdi_s = pins_s[0];

   ssl_edge u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .ck_s      (ck_s),
      .sel_s     (sel_s),
      .pha       (cfg_sck_pha),
      .sample_ev (sample_ev),
      .drive_ev  (drive_ev)
   );

   ssl_rx #(.DATA_W(DATA_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_s     (sel_s),
      .sample_ev (sample_ev),
      .sdi_s     (sdi_s),
      .byte_done (byte_done),
      .byte_val  (byte_val)
   );

   ssl_ctrl #(.DATA_W(DATA_W), .OP_W(OP_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_s     (sel_s),
      .byte_done (byte_done),
      .byte_val  (byte_val),
      .stb       (stb),
      .addr      (reg_addr),
      .wr_data   (wr_data)
   );

   assign cap_en   = stb.buf_rd | stb.reg_rd;
   assign cap_data = stb.buf_rd ? buf_rdata : reg_rdata;

   ssl_tx #(.DATA_W(DATA_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_s    (sel_s),
      .drive_ev (drive_ev),
      .cap_en   (cap_en),
      .cap_data (cap_data),
      .sdo      (sdo)
   );

   assign buf_rd_stb  = stb.buf_rd;
   assign buf_wr_stb  = stb.buf_wr;
   assign reg_rd_stb  = stb.reg_rd;
   assign reg_wr_stb  = stb.reg_wr;
   assign off_stb     = stb.off;
   assign irq_clr_stb = stb.irq_clr;

endmodule

// File: rtl/serial_cmd_slave_chk.sv
module serial_cmd_slave_chk #(
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_in,
   input logic              cfg_cs_pol,
   input logic              buf_rd_stb,
   input logic              buf_wr_stb,
   input logic              reg_rd_stb,
   input logic              reg_wr_stb,
   input logic              off_stb,
   input logic              irq_clr_stb,
   input logic [ADDR_W-1:0] reg_addr
);

   logic [5:0]        strb;
   logic              sel_pin;
   logic [2:0]        quiet;
   logic              rd_seen;
   logic              wr_seen;
   logic              sys_seen;
   logic [ADDR_W-1:0] last_rd;
   logic [ADDR_W-1:0] last_wr;

   assign strb    = {buf_rd_stb, buf_wr_stb, reg_rd_stb, reg_wr_stb, off_stb, irq_clr_stb};
   assign sel_pin = (cs_in == cfg_cs_pol);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quiet    <= '0;
         rd_seen  <= 1'b0;
         wr_seen  <= 1'b0;
         sys_seen <= 1'b0;
         last_rd  <= '0;
         last_wr  <= '0;
      end else begin
         if (sel_pin) quiet <= '0;
         else if (quiet != 3'd7) quiet <= quiet + 1'b1;
         if (!sel_pin) begin
            rd_seen  <= 1'b0;
            wr_seen  <= 1'b0;
            sys_seen <= 1'b0;
         end else begin
            if (reg_rd_stb) begin rd_seen <= 1'b1; last_rd <= reg_addr; end
            if (reg_wr_stb) begin wr_seen <= 1'b1; last_wr <= reg_addr; end
            if (off_stb || irq_clr_stb) sys_seen <= 1'b1;
         end
      end
   end

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(strb) <= 1); // R12
   AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (strb != '0) |=> (strb == '0)); // R12
   AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet >= 3'd4) |-> (strb == '0)); // R11
   AST_RD_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_stb && rd_seen) |-> (reg_addr == ADDR_W'(last_rd + 1'b1))); // R7
   AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_stb && wr_seen) |-> (reg_addr == ADDR_W'(last_wr + 1'b1))); // R8
   AST_SYS_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      sys_seen |-> (strb == '0)); // R9

endmodule

bind serial_cmd_slave serial_cmd_slave_chk #(.ADDR_W(FIELD_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cs_in       (cs_in),
   .cfg_cs_pol  (cfg_cs_pol),
   .buf_rd_stb  (buf_rd_stb),
   .buf_wr_stb  (buf_wr_stb),
   .reg_rd_stb  (reg_rd_stb),
   .reg_wr_stb  (reg_wr_stb),
   .off_stb     (off_stb),
   .irq_clr_stb (irq_clr_stb),
   .reg_addr    (reg_addr)
);

// File: tb/serial_cmd_slave_bench.sv
`timescale 1ns/1ps
module serial_cmd_slave_bench;

   localparam int HALF = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n;
   logic cfg_cs_pol, cfg_sck_pol, cfg_sck_pha, rx_transparent;
   logic sel, ck, sdi;
   logic cs_in, sck_in;
   logic sdo, sdo_oe;
   logic buf_rd_stb, buf_wr_stb, reg_rd_stb, reg_wr_stb, off_stb, irq_clr_stb;
   logic [4:0] reg_addr;
   logic [7:0] buf_rdata, reg_rdata, wr_data;
   logic [7:0] bcnt;

   int checks = 0;
   int fails  = 0;
   logic [16:0] exp_q[$];
   string       req_q[$];

   assign cs_in  = sel ? cfg_cs_pol : ~cfg_cs_pol;
   assign sck_in = ck ^ cfg_sck_pol;

   function automatic logic [7:0] regval(input logic [4:0] a);
      return {3'b000, a} * 8'd9 + 8'd1;
   endfunction

   assign reg_rdata = regval(reg_addr);
   assign buf_rdata = 8'hA0 + bcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bcnt <= '0;
      else if (buf_rd_stb) bcnt <= bcnt + 8'd1;
   end

   serial_cmd_slave u_serial_cmd_slave (
      .clk(clk), .rst_n(rst_n), .cfg_cs_pol(cfg_cs_pol), .cfg_sck_pol(cfg_sck_pol),
      .cfg_sck_pha(cfg_sck_pha), .rx_transparent(rx_transparent), .cs_in(cs_in),
      .sck_in(sck_in), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
      .buf_rd_stb(buf_rd_stb), .buf_wr_stb(buf_wr_stb), .buf_rdata(buf_rdata),
      .reg_rd_stb(reg_rd_stb), .reg_wr_stb(reg_wr_stb), .reg_addr(reg_addr),
      .reg_rdata(reg_rdata), .wr_data(wr_data), .off_stb(off_stb),
      .irq_clr_stb(irq_clr_stb)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // kinds: 1 buf write, 2 reg write, 3 buf read, 4 reg read, 5 off, 6 irq clear
   task automatic expect_ev(input string req, input logic [3:0] k, input logic [4:0] a,
                            input logic [7:0] d);
      exp_q.push_back({k, a, d});
      req_q.push_back(req);
   endtask

   // monitor: pops one expected item per observed strobe
   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         logic [5:0]  s;
         logic [16:0] item;
         s = {buf_rd_stb, buf_wr_stb, reg_rd_stb, reg_wr_stb, off_stb, irq_clr_stb};
         if (s != '0) begin
            chk("R12", "strobes in one cycle", 32'($countones(s)), 32'd1);
            if (buf_wr_stb)      item = {4'd1, 5'd0, wr_data};
            else if (reg_wr_stb) item = {4'd2, reg_addr, wr_data};
            else if (buf_rd_stb) item = {4'd3, 5'd0, 8'd0};
            else if (reg_rd_stb) item = {4'd4, reg_addr, 8'd0};
            else if (off_stb)    item = {4'd5, 5'd0, 8'd0};
            else                 item = {4'd6, 5'd0, 8'd0};
            if (exp_q.size() == 0) begin
               checks++;
               fails++;
               $display("FAIL R12 unexpected strobe actual=%0h expected=none", item);
            end else begin
               string r;
               logic [16:0] e;
               e = exp_q.pop_front();
               r = req_q.pop_front();
               chk(r, "strobe event", 32'(item), 32'(e));
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
      rx = '0;
      for (int i = 0; i < n; i++) begin
         if (!cfg_sck_pha) begin
            sdi = tx[7-i];
            tick(HALF);
            rx[7-i] = sdo;
            ck = 1'b1;
            tick(HALF);
            ck = 1'b0;
         end else begin
            ck  = 1'b1;
            sdi = tx[7-i];
            tick(HALF);
            rx[7-i] = sdo;
            ck = 1'b0;
            tick(HALF);
         end
      end
   endtask

   task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
      xbits(tx, 8, rx);
   endtask

   task automatic set_mode(input logic cp, input logic sp, input logic sh);
      cfg_cs_pol  = cp;
      cfg_sck_pol = sp;
      cfg_sck_pha = sh;
      tick(6);
   endtask

   task automatic open_frame();
      sel = 1'b1;
      tick(4);
   endtask

   task automatic close_frame();
      tick(HALF);
      sel = 1'b0;
      tick(12);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] rx;
      logic [7:0] base;
      rst_n = 1'b0;
      cfg_cs_pol = 1'b0; cfg_sck_pol = 1'b0; cfg_sck_pha = 1'b0;
      rx_transparent = 1'b0;
      sel = 1'b0; ck = 1'b0; sdi = 1'b0;
      tick(5);
      rst_n = 1'b1;
      tick(5);

      // reset state
      chk("R2", "oe after reset", 32'(sdo_oe), 32'd0);
      chk("R2", "sdo after reset", 32'(sdo), 32'd0);
      rx_transparent = 1'b1;
      tick(1);
      chk("R2", "oe forced by transparent", 32'(sdo_oe), 32'd1);
      rx_transparent = 1'b0;
      tick(1);

      // R1 R8: active-high select, register write with address step
      set_mode(1'b1, 1'b0, 1'b0);
      expect_ev("R8", 4'd2, 5'd3, 8'h11);
      expect_ev("R8", 4'd2, 5'd4, 8'h22);
      open_frame();
      chk("R2", "oe while selected", 32'(sdo_oe), 32'd1);
      xbyte(8'h63, rx);
      xbyte(8'h11, rx);
      xbyte(8'h22, rx);
      close_frame();
      chk("R1", "oe after release", 32'(sdo_oe), 32'd0);

      // R7: register read with wrap 31 -> 0
      expect_ev("R7", 4'd4, 5'd31, 8'd0);
      expect_ev("R7", 4'd4, 5'd0, 8'd0);
      expect_ev("R7", 4'd4, 5'd1, 8'd0);
      open_frame();
      xbyte(8'h5F, rx);
      xbyte(8'h00, rx);
      chk("R7", "read byte at 31", 32'(rx), 32'(regval(5'd31)));
      xbyte(8'h00, rx);
      chk("R7", "read byte after wrap", 32'(rx), 32'(regval(5'd0)));
      close_frame();

      // R5 R3: buffer read, count 2, sck_pol=1 pha=0
      set_mode(1'b1, 1'b1, 1'b0);
      base = bcnt;
      expect_ev("R5", 4'd3, 5'd0, 8'd0);
      expect_ev("R5", 4'd3, 5'd0, 8'd0);
      open_frame();
      xbyte(8'h02, rx);
      xbyte(8'h00, rx);
      chk("R5", "buffer byte 0", 32'(rx), 32'(8'hA0 + base));
      xbyte(8'h00, rx);
      chk("R5", "buffer byte 1", 32'(rx), 32'(8'hA1 + base));
      xbyte(8'h00, rx);
      chk("R5", "byte past count", 32'(rx), 32'd0);
      close_frame();

      // R6 R3: buffer write count 1, pha=1, extra byte ignored
      set_mode(1'b1, 1'b0, 1'b1);
      expect_ev("R6", 4'd1, 5'd0, 8'h5C);
      open_frame();
      xbyte(8'h21, rx);
      xbyte(8'h5C, rx);
      xbyte(8'h77, rx);
      close_frame();

      // R9 R1: off command with active-low select, trailing byte ignored
      set_mode(1'b0, 1'b0, 1'b0);
      chk("R1", "oe idle active-low", 32'(sdo_oe), 32'd0);
      expect_ev("R9", 4'd5, 5'd0, 8'd0);
      open_frame();
      chk("R1", "oe selected active-low", 32'(sdo_oe), 32'd1);
      xbyte(8'h9F, rx);
      xbyte(8'h44, rx);
      close_frame();

      // R9 R3: interrupt clear in mode pol=1 pha=1
      set_mode(1'b1, 1'b1, 1'b1);
      expect_ev("R9", 4'd6, 5'd0, 8'd0);
      open_frame();
      xbyte(8'hA0, rx);
      close_frame();

      // R10: unused opcodes
      open_frame();
      xbyte(8'hC5, rx);
      xbyte(8'hFF, rx);
      chk("R10", "sdo after opcode 110", 32'(rx), 32'd0);
      close_frame();
      open_frame();
      xbyte(8'hE3, rx);
      xbyte(8'h0F, rx);
      chk("R10", "sdo after opcode 111", 32'(rx), 32'd0);
      close_frame();

      // R3: register read in mode pol=1 pha=1
      expect_ev("R3", 4'd4, 5'd2, 8'd0);
      expect_ev("R3", 4'd4, 5'd3, 8'd0);
      open_frame();
      xbyte(8'h42, rx);
      xbyte(8'h00, rx);
      chk("R3", "read byte mode 3", 32'(rx), 32'(regval(5'd2)));
      close_frame();

      // R11: abort mid-byte, then fresh command
      set_mode(1'b0, 1'b0, 1'b0);
      expect_ev("R11", 4'd2, 5'd5, 8'hAA);
      open_frame();
      xbyte(8'h65, rx);
      xbyte(8'hAA, rx);
      xbits(8'h3C, 4, rx);
      sel = 1'b0;
      tick(12);
      expect_ev("R11", 4'd4, 5'd7, 8'd0);
      expect_ev("R11", 4'd4, 5'd8, 8'd0);
      open_frame();
      xbyte(8'h47, rx);
      xbyte(8'h00, rx);
      chk("R11", "fresh frame read", 32'(rx), 32'(regval(5'd7)));
      close_frame();

      // R5: buffer read with count 0
      open_frame();
      xbyte(8'h00, rx);
      xbyte(8'h00, rx);
      chk("R5", "count zero data", 32'(rx), 32'd0);
      close_frame();

      // R4: every decoded command produced its events
      chk("R4", "pending events", 32'(exp_q.size()), 32'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule